// File: doc/BRIEF.md
# Relocatable RAM and Register-Block Address Decoder

This block watches a 16-bit CPU address bus and decides, in the same cycle, whether the address falls in a 1 KB internal RAM window, in a 96-byte register window, or in neither. When neither window matches, it selects external memory. Each window can sit on any 4 KB page. The page of each window comes from an 8-bit mapping register. The upper nibble of that register picks the RAM page and the lower nibble picks the register page. Along with the one-hot select, the block gives the offset of the address inside the chosen window.

The mapping register lives at offset 0x3D of the register window, so it moves whenever the register window moves. Its write rule depends on the mode. In normal operation the register takes one write at most, and only during the first 64 clocks after reset. When the special-mode input is high, it takes any number of writes at any time. The block has no data stream. The bus is a plain one-access-per-clock interface with a write strobe, so it has no back-pressure: every cycle's address is decoded, and every qualifying write is acted on at the next clock edge.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset the mapping register reads 0x01. This puts RAM at 0x0000–0x03FF and the register window at 0x1000–0x105F.
- R2: Let B be mapping bits [7:4] shifted left by 12. Addresses from B to B+0x3FF select RAM (output bit pattern ram=1), and win_offset = addr − B.
- R3: Let B be mapping bits [3:0] shifted left by 12. Addresses from B to B+0x05F select the register window, and win_offset = addr − B. Address B+0x060 is not in this window.
- R4: When the two windows share a page, an address inside the register window selects registers, not RAM.
- R5: Exactly one of ram_sel, reg_sel and ext_sel is high in every cycle. Any address outside both windows raises ext_sel, and win_offset then equals the address.
- R6: The mapping register is at register-window offset 0x3D. map_hit is high for that address, and map_value always shows the register contents. A write needs wr_en high while map_hit is high.
- R7: In normal mode (special_mode low), a write is taken only at one of the first 64 rising edges after reset is released. A write at the 65th edge or later is ignored.
- R8: In normal mode, only the first accepted write takes effect. A second write is ignored even inside the 64-edge window.
- R9: With special_mode high, every write to the mapping register is taken, at any time and any number of times.
- R10: Decoding is combinational from the address and the register. A write that moves a window changes decoding from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one access per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| special_mode | input | 1 | High: the mapping register may be written at any time |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | Write strobe for the current address |
| wdata | input | 8 | Write data |
| ram_sel | output | 1 | Address is in the RAM window |
| reg_sel | output | 1 | Address is in the register window |
| ext_sel | output | 1 | Address is in neither window |
| win_offset | output | 16 | Offset inside the selected window (the full address when external) |
| map_hit | output | 1 | Address is the mapping register |
| map_value | output | 8 | Current mapping register contents |

## Verification
The selects, win_offset and map_hit depend only on the inputs of the current cycle, so the bench drives the address at the falling edge and reads these outputs one nanosecond later, in the same cycle. map_value and the decoding that follows from it change only at the rising edge that takes a write. Every write check therefore reads at the next falling edge, and one check reads before that edge to confirm the old mapping still holds. For the 64-edge limit, the bench counts rising edges from the release of reset. It places one write on the 64th edge and one on the 65th, each after a fresh reset.

// File: rtl/amap_pkg.sv
package amap_pkg;

  typedef enum logic [1:0] {
    TGT_EXT = 2'd0,
    TGT_RAM = 2'd1,
    TGT_REG = 2'd2
  } target_e;

  // One-hot select vector ordered {ram, reg, ext}
  function automatic logic [2:0] target_onehot(target_e t);
    case (t)
      TGT_RAM: return 3'b100;
      TGT_REG: return 3'b010;
      default: return 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/amap_window.sv
// Page-relative window comparator: matches one page number and an
// in-page limit, and reports the in-page offset.
module amap_window #(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 4,
  parameter int SIZE    = 1024
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] page,
  output logic               hit,
  output logic [ADDR_W-1:0]  offset
);
  localparam int LOW_W = ADDR_W - FIELD_W;
  localparam int PAGE_SPAN = 1 << LOW_W;

  logic page_match;
  logic low_match;

  assign page_match = (addr[ADDR_W-1 -: FIELD_W] == page);

  generate
    if (SIZE >= PAGE_SPAN) begin : g_full_page
      assign low_match = 1'b1;
    end else begin : g_part_page
      localparam logic [LOW_W-1:0] LIMIT = LOW_W'(SIZE);
      assign low_match = (addr[LOW_W-1:0] < LIMIT);
    end
  endgenerate

  assign hit    = page_match && low_match;
  assign offset = {{FIELD_W{1'b0}}, addr[LOW_W-1:0]};

endmodule

// File: rtl/amap_select.sv
// Resolves the window hits into one target; registers win over RAM.
module amap_select
  import amap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ram_hit,
  input  logic [ADDR_W-1:0] ram_off,
  input  logic              reg_hit,
  input  logic [ADDR_W-1:0] reg_off,
  output logic              ram_sel,
  output logic              reg_sel,
  output logic              ext_sel,
  output logic [ADDR_W-1:0] offset
);
  target_e tgt;

  always_comb begin
    if (reg_hit)      tgt = TGT_REG;
    else if (ram_hit) tgt = TGT_RAM;
    else              tgt = TGT_EXT;
  end

  always_comb begin
    case (tgt)
      TGT_REG: offset = reg_off;
      TGT_RAM: offset = ram_off;
      default: offset = addr;
    endcase
  end

  assign {ram_sel, reg_sel, ext_sel} = target_onehot(tgt);

endmodule

// File: rtl/amap_ctrl.sv
// Mapping register with a boot-time write window and a written-once lock.
module amap_ctrl #(
  parameter int              DATA_W      = 8,
  parameter int              OPEN_CYCLES = 64,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] map_q
);
  localparam int CNT_W = $clog2(OPEN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(OPEN_CYCLES);

  logic [CNT_W-1:0] age_q;
  logic             written_q;
  logic             window_open;
  logic             accept;

  assign window_open = (age_q < CNT_LIMIT) && !written_q;
  assign accept      = wr_hit && (special_mode || window_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != CNT_LIMIT) begin
      age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q     <= RESET_VAL;
      written_q <= 1'b0;
    end else if (accept) begin
      map_q     <= wdata;
      written_q <= 1'b1;
    end
  end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int              ADDR_W      = 16,
  parameter int              DATA_W      = 8,
  parameter int              RAM_BYTES   = 1024,
  parameter int              REG_BYTES   = 96,
  parameter int              MAP_OFFSET  = 'h3D,
  parameter int              OPEN_CYCLES = 64,
  parameter logic [DATA_W-1:0] RESET_MAP = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              ram_sel,
  output logic              reg_sel,
  output logic              ext_sel,
  output logic [ADDR_W-1:0] win_offset,
  output logic              map_hit,
  output logic [DATA_W-1:0] map_value
);
  localparam int FIELD_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] MAP_OFF = ADDR_W'(MAP_OFFSET);

  logic [DATA_W-1:0] map_q;
  logic              ram_hit, reg_hit;
  logic [ADDR_W-1:0] ram_off, reg_off;

  amap_window #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SIZE(RAM_BYTES)) u_ram_win (
    .addr(addr), .page(map_q[DATA_W-1 -: FIELD_W]), .hit(ram_hit), .offset(ram_off)
  );

  amap_window #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SIZE(REG_BYTES)) u_reg_win (
    .addr(addr), .page(map_q[FIELD_W-1:0]), .hit(reg_hit), .offset(reg_off)
  );

  amap_select #(.ADDR_W(ADDR_W)) u_sel (
    .addr(addr), .ram_hit(ram_hit), .ram_off(ram_off),
    .reg_hit(reg_hit), .reg_off(reg_off),
    .ram_sel(ram_sel), .reg_sel(reg_sel), .ext_sel(ext_sel), .offset(win_offset)
  );

  assign map_hit = reg_hit && (reg_off == MAP_OFF);

  amap_ctrl #(.DATA_W(DATA_W), .OPEN_CYCLES(OPEN_CYCLES), .RESET_VAL(RESET_MAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .wr_hit(wr_en && map_hit), .wdata(wdata), .map_q(map_q)
  );

  assign map_value = map_q;

endmodule

// File: rtl/amap_checker.sv
module amap_checker #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int REG_BYTES   = 96,
  parameter int OPEN_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              special_mode,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              ram_sel,
  input logic              reg_sel,
  input logic              ext_sel,
  input logic [ADDR_W-1:0] win_offset,
  input logic              map_hit,
  input logic [DATA_W-1:0] map_value
);
  localparam int FW = DATA_W / 2;
  localparam int LW = ADDR_W - FW;

  int unsigned edges;
  always_ff @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else if (edges < OPEN_CYCLES + 1) edges <= edges + 1;
  end

  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ram_sel, reg_sel, ext_sel}) == 1);

  p_reg_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1 -: FW] == map_value[FW-1:0] && int'(addr[LW-1:0]) < REG_BYTES) |-> reg_sel);

  p_ram_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (win_offset == addr - {map_value[DATA_W-1 -: FW], {LW{1'b0}}}));

  p_late_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_mode && edges >= OPEN_CYCLES) |=> $stable(map_value));

  p_special_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && wr_en && map_hit) |=> (map_value == $past(wdata)));

endmodule

bind addr_window_decoder amap_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BYTES(REG_BYTES), .OPEN_CYCLES(OPEN_CYCLES)
) u_amap_checker (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .addr(addr),
  .wr_en(wr_en), .wdata(wdata), .ram_sel(ram_sel), .reg_sel(reg_sel),
  .ext_sel(ext_sel), .win_offset(win_offset), .map_hit(map_hit), .map_value(map_value)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        special_mode = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        ram_sel, reg_sel, ext_sel, map_hit;
  logic [15:0] win_offset;
  logic [7:0]  map_value;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  logic [7:0]  cur_map = 8'h01;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .ram_sel(ram_sel), .reg_sel(reg_sel),
    .ext_sel(ext_sel), .win_offset(win_offset), .map_hit(map_hit), .map_value(map_value)
  );

  // {map[7:0], addr[15:0], sel{ram,reg,ext}[2:0], offset[15:0]}
  localparam logic [42:0] VECS [14] = '{
    {8'h01, 16'h0000, 3'b100, 16'h0000},
    {8'h01, 16'h03FF, 3'b100, 16'h03FF},
    {8'h01, 16'h0400, 3'b001, 16'h0400},
    {8'h01, 16'h1000, 3'b010, 16'h0000},
    {8'h01, 16'h105F, 3'b010, 16'h005F},
    {8'h01, 16'h1060, 3'b001, 16'h1060},
    {8'h33, 16'h3000, 3'b010, 16'h0000},
    {8'h33, 16'h305F, 3'b010, 16'h005F},
    {8'h33, 16'h3060, 3'b100, 16'h0060},
    {8'h33, 16'h33FF, 3'b100, 16'h03FF},
    {8'h33, 16'h3400, 3'b001, 16'h3400},
    {8'hA5, 16'hA010, 3'b100, 16'h0010},
    {8'hA5, 16'h5010, 3'b010, 16'h0010},
    {8'hFF, 16'hFFFF, 3'b001, 16'hFFFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; special_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_map = 8'h01;
  endtask

  // One write to the mapping register at the next rising edge; returns at the next falling edge.
  task automatic write_map(logic [7:0] v);
    addr = {cur_map[3:0], 12'h03D};
    wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    cur_map = map_value;
  endtask

  task automatic probe(string req, logic [15:0] a, logic [2:0] sel, logic [15:0] off);
    addr = a;
    #1;
    check(req, {ram_sel, reg_sel, ext_sel}, sel);
    check(req, win_offset, off);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset value and map_hit at reset location (R6)
    addr = 16'h103D; #1;
    check("R1", map_value, 8'h01);
    check("R6", map_hit, 1'b1);
    addr = 16'h003D; #1;
    check("R6", map_hit, 1'b0);

    // Table walk, mapping set in special mode (R2 R3 R4 R5)
    special_mode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 14; i++) begin
      if (VECS[i][42:35] != cur_map) write_map(VECS[i][42:35]);
      probe("R2/R3/R4/R5", VECS[i][34:19], VECS[i][18:16], VECS[i][15:0]);
      @(negedge clk);
    end

    // RAM window at all 16 pages (R2)
    for (int p = 0; p < 16; p++) begin
      write_map({4'(p), 4'(p + 8)});
      check("R9", map_value, {4'(p), 4'(p + 8)});
      probe("R2", {4'(p), 12'h000}, 3'b100, 16'h0000);
      probe("R2", {4'(p), 12'h3FF}, 3'b100, 16'h03FF);
      probe("R5", {4'(p), 12'h400}, 3'b001, {4'(p), 12'h400});
      @(negedge clk);
    end

    // Register window at all 16 pages (R3)
    for (int p = 0; p < 16; p++) begin
      write_map({4'(p + 8), 4'(p)});
      probe("R3", {4'(p), 12'h000}, 3'b010, 16'h0000);
      probe("R3", {4'(p), 12'h05F}, 3'b010, 16'h005F);
      probe("R3", {4'(p), 12'h060}, 3'b001, {4'(p), 12'h060});
      addr = {4'(p), 12'h03D}; #1;
      check("R6", map_hit, 1'b1);
      @(negedge clk);
    end

    // R10: old decode holds before the edge, new decode after it
    write_map(8'h01);
    addr = 16'h103D; wdata = 8'h22; wr_en = 1'b1; #1;
    check("R10", reg_sel, 1'b1);
    @(negedge clk); wr_en = 1'b0; cur_map = 8'h22; #1;
    check("R10", ext_sel, 1'b1);
    check("R10", map_value, 8'h22);

    // R7: write at the 64th edge is taken
    do_reset();
    repeat (63) @(negedge clk);
    write_map(8'h45);
    check("R7", map_value, 8'h45);

    // R7: write at the 65th edge is ignored
    do_reset();
    repeat (64) @(negedge clk);
    write_map(8'h45);
    check("R7", map_value, 8'h01);
    probe("R7", 16'h0000, 3'b100, 16'h0000);

    // R8: second write inside the window is ignored
    do_reset();
    write_map(8'h23);
    check("R8", map_value, 8'h23);
    write_map(8'h56);
    check("R8", map_value, 8'h23);
    probe("R8", 16'h2000, 3'b100, 16'h0000);

    // R9: special mode after the window, repeated writes
    repeat (80) @(negedge clk);
    special_mode = 1'b1;
    write_map(8'h7C);
    check("R9", map_value, 8'h7C);
    write_map(8'h9E);
    check("R9", map_value, 8'h9E);
    probe("R9", 16'hE010, 3'b010, 16'h0010);
    special_mode = 1'b0;
    write_map(8'h11);
    check("R7", map_value, 8'h9E);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule